// File: doc/BRIEF.md
# Extended Twelve-Register Bank File

This block holds the bank-switching state of a cartridge memory controller. A CPU write port, decoded with the mask $E001, reaches three registers: a bank-select register at even addresses in $8000-$9FFF, a bank-data port at odd addresses in the same range, and a mirroring register at even addresses in $A000-$BFFF. The select register names one of twelve bank registers and carries two inversion flags. The data port loads the named bank register.

From this state the block drives a bank number for each of the four 8 KiB CPU windows ($8000, $A000, $C000, $E000) and for each of the eight 1 KiB PPU windows. It also drives a two-bit mirroring code. In legacy mode the block acts as the classic eight-register controller: there are two 2 KiB pattern windows, and the two upper CPU windows are fixed. When the level input `ext_mode` is high, four more registers take effect. They split the 2 KiB windows into 1 KiB windows, make every CPU window selectable, and widen mirroring to include single-screen pages. A configuration input swaps the targets of two select values for boards that expect that ordering. The outer-bank combining and any scanline counter sit outside this block.

Top module: `bankfile_xmmc`

## Requirements
- R1: After reset, registers 0-7 hold 00,02,04,05,06,07,00,01 and registers 8-11 hold FE,FF,FF,FF. All select and mirroring state is zero. The reset values are visible on the window outputs in both modes.
- R2: Only writes with `wr_en` high are decoded, and the decode is on address bits 15:13 and bit 0. The select register answers at 100/even, the data port at 100/odd and mirroring at 101/even. Any other address changes nothing.
- R3: In legacy mode, with select bit 7 clear, index 0 drives PPU windows 0-1 and index 1 drives windows 2-3. In each of these pairs the bank's bit 0 is forced to 0 in the lower window and to 1 in the upper window. Indices 2-5 drive windows 4-7 one to one.
- R4: In extended mode, with select bit 7 clear, PPU windows 0..7 show registers 0,10,1,11,2,3,4,5.
- R5: Select bit 7 exchanges PPU windows 0-3 with windows 4-7, in both modes.
- R6: In legacy mode the $A000 window shows register 7 and the $E000 window shows the all-ones bank. The $8000 window shows register 6 and the $C000 window shows all-ones minus one. Select bit 6 set exchanges the $8000 and $C000 windows.
- R7: In extended mode the CPU windows show registers 6,7,8,9. Select bit 6 set exchanges the $8000 and $C000 windows.
- R8: In legacy mode a data write uses only select bits 2:0 as the index, so registers 8-11 keep their values. In extended mode bits 3:0 are the index, and indices 12-15 write nothing.
- R9: The mirroring write stores data bits 1:0. The output code is 0 vertical, 1 horizontal, 2 single page 0 and 3 single page 1. In legacy mode output bit 1 reads 0.
- R10: With `swap_67` high, a data write whose select value has bit 6 set and index 6 loads register 7, and one with index 7 loads register 6. When bit 6 is clear there is no exchange.
- R11: `ext_mode` is a level. Changing it alters the outputs at once, with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_mode | input | 1 | Level select of twelve-register mode |
| swap_67 | input | 1 | Exchange targets of select values with bit 6 and index 6/7 |
| chr_bank_flat | output | 8*BANK_W | Bank per 1 KiB PPU window, window k in bits k*BANK_W upward |
| prg_bank_flat | output | 4*BANK_W | Bank per 8 KiB CPU window, $8000 window lowest |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The bench sweeps all sixteen index values under all four inversion combinations in both modes. After every write it compares all thirteen outputs against a model built from the requirements. This catches a mis-ordered window table, which would show a neighbouring register in the wrong 1 KiB window. It also catches a 2 KiB pair that keeps the stored bit 0, which would repeat a bank in both halves, and legacy writes to index 8-15 that corrupt registers 8-11. Further writes go to addresses just outside the decoded ranges, and others are made with the strobe low, to expose a decoder that is too loose. Select values 46/47 and 06/07 are written with the swap option in both states, and the mode input is toggled with no write in between, to expose a mode that is latched instead of level-driven.

// File: rtl/bankfile_pkg.sv
package bankfile_pkg;
   localparam int NUM_REGS  = 12;
   localparam int CHR_WINS  = 8;
   localparam int PRG_WINS  = 4;
   localparam int IDX_W     = 4;

   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORIZ  = 2'd1,
      MIR_PAGE0  = 2'd2,
      MIR_PAGE1  = 2'd3
   } mirror_e;

   // power-up contents of the eight legacy bank registers
   function automatic int legacy_reset(input int i);
      case (i)
         0: return 0;
         1: return 2;
         2: return 4;
         3: return 5;
         4: return 6;
         5: return 7;
         6: return 0;
         7: return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/bfx_write_decode.sv
module bfx_write_decode
   import bankfile_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              ext_mode,
   input  logic              swap_67,
   output logic              chr_inv,
   output logic              prg_inv,
   output logic [1:0]        mir_q,
   output logic              data_we,
   output logic [IDX_W-1:0]  data_idx,
   output logic [BANK_W-1:0] data_val
);
   localparam logic [2:0] SEG_BANK = 3'b100;
   localparam logic [2:0] SEG_MIR  = 3'b101;
   localparam logic [IDX_W-1:0] IDX_A = IDX_W'(6);
   localparam logic [IDX_W-1:0] IDX_B = IDX_W'(7);
   localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_REGS);

   if (BANK_W < 2 || BANK_W > 8) begin : g_bad_width
      $error("bfx_write_decode: BANK_W must lie in 2..8");
   end

   logic              hit_sel, hit_dat, hit_mir;
   logic [IDX_W-1:0]  sel_idx;
   logic [IDX_W-1:0]  idx_raw;
   logic              unused_addr;

   assign unused_addr = ^wr_addr[12:1];

   always_comb begin
      hit_sel = wr_en && (wr_addr[15:13] == SEG_BANK) && !wr_addr[0];
      hit_dat = wr_en && (wr_addr[15:13] == SEG_BANK) &&  wr_addr[0];
      hit_mir = wr_en && (wr_addr[15:13] == SEG_MIR)  && !wr_addr[0];
   end

   // index width depends on mode; optional exchange of two targets
   always_comb begin
      idx_raw  = ext_mode ? sel_idx : {1'b0, sel_idx[2:0]};
      data_idx = idx_raw;
      if (swap_67 && prg_inv) begin
         if (idx_raw == IDX_A)      data_idx = IDX_B;
         else if (idx_raw == IDX_B) data_idx = IDX_A;
      end
      data_we  = hit_dat && (data_idx < IDX_LIM);
      data_val = wr_data[BANK_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_idx <= '0;
         prg_inv <= 1'b0;
         chr_inv <= 1'b0;
         mir_q   <= MIR_VERT;
      end else begin
         if (hit_sel) begin
            sel_idx <= wr_data[3:0];
            prg_inv <= wr_data[6];
            chr_inv <= wr_data[7];
         end
         if (hit_mir) mir_q <= wr_data[1:0];
      end
   end

   p_sel_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0])
      |=> ({chr_inv, prg_inv, sel_idx} == {$past(wr_data[7:6]), $past(wr_data[3:0])}));

   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0])
      |=> $stable({chr_inv, prg_inv, sel_idx}));

   p_mir_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0])
      |=> (mir_q == $past(wr_data[1:0])));

   p_legacy_low_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !ext_mode) |-> (data_idx < IDX_W'(8)));
endmodule

// File: rtl/bfx_reg_file.sv
module bfx_reg_file
   import bankfile_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ext_mode,
   input  logic                       we,
   input  logic [IDX_W-1:0]           idx,
   input  logic [BANK_W-1:0]          wdata,
   output logic [NUM_REGS*BANK_W-1:0] regs_flat
);
   localparam logic [BANK_W-1:0] ONES = '1;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [BANK_W-1:0] RV =
         (i == 8) ? (ONES - BANK_W'(1)) :
         (i > 8)  ? ONES : BANK_W'(legacy_reset(i));
      logic [BANK_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       q <= RV;
         else if (we && idx == IDX_W'(i))  q <= wdata;
      end
      assign regs_flat[i*BANK_W +: BANK_W] = q;
   end

   p_ext_regs_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |=> $stable(regs_flat[NUM_REGS*BANK_W-1 : 8*BANK_W]));
endmodule

// File: rtl/bfx_chr_map.sv
module bfx_chr_map
   import bankfile_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ext_mode,
   input  logic                       chr_inv,
   input  logic [CHR_WINS*BANK_W-1:0] chr_regs,
   output logic [CHR_WINS*BANK_W-1:0] chr_bank_flat
);
   // slot packing of chr_regs: 0..5 = registers 0..5, 6 = register 10, 7 = register 11
   function automatic int ext_slot(input int p);
      case (p)
         0: return 0;
         1: return 6;
         2: return 1;
         3: return 7;
         4: return 2;
         5: return 3;
         6: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic int leg_slot(input int p);
      return (p < 4) ? (p / 2) : (p - 2);
   endfunction

   logic [BANK_W-1:0] slot [CHR_WINS];
   for (genvar k = 0; k < CHR_WINS; k++) begin : g_slot
      assign slot[k] = chr_regs[k*BANK_W +: BANK_W];
   end

   for (genvar w = 0; w < CHR_WINS; w++) begin : g_win
      logic [BANK_W-1:0] cand [2];
      for (genvar a = 0; a < 2; a++) begin : g_alt
         localparam int POS  = w ^ (a * 4);
         localparam int ES   = ext_slot(POS);
         localparam int LS   = leg_slot(POS);
         localparam bit PAIR = (POS < 4);
         localparam logic LOWB = 1'(POS % 2);
         if (PAIR) begin : g_pair
            assign cand[a] = ext_mode ? slot[ES] : {slot[LS][BANK_W-1:1], LOWB};
         end else begin : g_single
            assign cand[a] = ext_mode ? slot[ES] : slot[LS];
         end
      end
      assign chr_bank_flat[w*BANK_W +: BANK_W] = chr_inv ? cand[1] : cand[0];
   end

   p_chr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && !chr_inv) |->
         (chr_bank_flat[BANK_W-1:1] == chr_bank_flat[2*BANK_W-1:BANK_W+1]) &&
         !chr_bank_flat[0] && chr_bank_flat[BANK_W]);

   p_chr_inv_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && chr_inv) |->
         (chr_bank_flat[5*BANK_W-1:4*BANK_W+1] == chr_bank_flat[6*BANK_W-1:5*BANK_W+1]) &&
         !chr_bank_flat[4*BANK_W] && chr_bank_flat[5*BANK_W]);
endmodule

// File: rtl/bfx_prg_map.sv
module bfx_prg_map
   import bankfile_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ext_mode,
   input  logic                       prg_inv,
   input  logic [PRG_WINS*BANK_W-1:0] prg_regs,
   output logic [PRG_WINS*BANK_W-1:0] prg_bank_flat
);
   localparam logic [BANK_W-1:0] LAST   = '1;
   localparam logic [BANK_W-1:0] SECOND = LAST - BANK_W'(1);

   logic [BANK_W-1:0] s [PRG_WINS];
   logic [BANK_W-1:0] w [PRG_WINS];

   for (genvar k = 0; k < PRG_WINS; k++) begin : g_io
      assign s[k] = prg_regs[k*BANK_W +: BANK_W];
      assign prg_bank_flat[k*BANK_W +: BANK_W] = w[k];
   end

   always_comb begin
      w[1] = s[1];
      if (ext_mode) begin
         w[0] = prg_inv ? s[2] : s[0];
         w[2] = prg_inv ? s[0] : s[2];
         w[3] = s[3];
      end else begin
         w[0] = prg_inv ? SECOND : s[0];
         w[2] = prg_inv ? s[0]   : SECOND;
         w[3] = LAST;
      end
   end

   p_last_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (prg_bank_flat[4*BANK_W-1:3*BANK_W] == LAST));

   p_second_somewhere_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (prg_bank_flat[BANK_W-1:0] == SECOND ||
                     prg_bank_flat[3*BANK_W-1:2*BANK_W] == SECOND));

   p_window1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(prg_regs) && $stable(ext_mode) && !$stable(prg_inv)
      |-> $stable(prg_bank_flat[2*BANK_W-1:BANK_W]));
endmodule

// File: rtl/bankfile_xmmc.sv
module bankfile_xmmc
   import bankfile_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [15:0]                wr_addr,
   input  logic [7:0]                 wr_data,
   input  logic                       ext_mode,
   input  logic                       swap_67,
   output logic [CHR_WINS*BANK_W-1:0] chr_bank_flat,
   output logic [PRG_WINS*BANK_W-1:0] prg_bank_flat,
   output logic [1:0]                 mirror_mode
);
   logic                       chr_inv, prg_inv, data_we;
   logic [1:0]                 mir_q;
   logic [IDX_W-1:0]           data_idx;
   logic [BANK_W-1:0]          data_val;
   logic [NUM_REGS*BANK_W-1:0] regs_flat;
   logic [CHR_WINS*BANK_W-1:0] chr_regs;
   logic [PRG_WINS*BANK_W-1:0] prg_regs;

   bfx_write_decode #(.BANK_W(BANK_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_mode(ext_mode), .swap_67(swap_67),
      .chr_inv(chr_inv), .prg_inv(prg_inv), .mir_q(mir_q),
      .data_we(data_we), .data_idx(data_idx), .data_val(data_val));

   bfx_reg_file #(.BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .we(data_we),
      .idx(data_idx), .wdata(data_val), .regs_flat(regs_flat));

   assign chr_regs = {regs_flat[11*BANK_W +: BANK_W],
                      regs_flat[10*BANK_W +: BANK_W],
                      regs_flat[0 +: 6*BANK_W]};
   assign prg_regs = regs_flat[6*BANK_W +: 4*BANK_W];

   bfx_chr_map #(.BANK_W(BANK_W)) u_chr (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .chr_inv(chr_inv),
      .chr_regs(chr_regs), .chr_bank_flat(chr_bank_flat));

   bfx_prg_map #(.BANK_W(BANK_W)) u_prg (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .prg_inv(prg_inv),
      .prg_regs(prg_regs), .prg_bank_flat(prg_bank_flat));

   always_comb mirror_mode = ext_mode ? mir_q : {1'b0, mir_q[0]};

   p_mir_legacy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && $stable(ext_mode)) |-> $stable(mirror_mode[1]));
endmodule

// File: tb/bankfile_xmmc_tb.sv
module bankfile_xmmc_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        ext_mode = 1'b0;
   logic        swap_67 = 1'b0;
   logic [63:0] chr_bank_flat;
   logic [31:0] prg_bank_flat;
   logic [1:0]  mirror_mode;

   int total = 0;
   int bad = 0;

   logic [7:0] m [12];
   logic [7:0] msel;
   logic [1:0] mmir;

   always #(PERIOD/2) clk = ~clk;

   bankfile_xmmc u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_mode(ext_mode), .swap_67(swap_67),
      .chr_bank_flat(chr_bank_flat), .prg_bank_flat(prg_bank_flat),
      .mirror_mode(mirror_mode));

   function automatic logic [7:0] exp_chr(input int w);
      int ww;
      ww = w ^ (msel[7] ? 4 : 0);
      if (ext_mode) begin
         case (ww)
            0: return m[0];
            1: return m[10];
            2: return m[1];
            3: return m[11];
            4: return m[2];
            5: return m[3];
            6: return m[4];
            default: return m[5];
         endcase
      end
      if (ww < 4) return (m[ww/2] & 8'hFE) | 8'(ww % 2);
      return m[ww-2];
   endfunction

   function automatic logic [7:0] exp_prg(input int p);
      logic inv;
      inv = msel[6];
      if (ext_mode) begin
         case (p)
            0: return inv ? m[8] : m[6];
            1: return m[7];
            2: return inv ? m[6] : m[8];
            default: return m[9];
         endcase
      end
      case (p)
         0: return inv ? 8'hFE : m[6];
         1: return m[7];
         2: return inv ? m[6] : 8'hFE;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int w = 0; w < 8; w++)
         chk(tag, $sformatf("chr%0d", w), chr_bank_flat[w*8 +: 8], exp_chr(w));
      for (int p = 0; p < 4; p++)
         chk(tag, $sformatf("prg%0d", p), prg_bank_flat[p*8 +: 8], exp_prg(p));
      chk(tag, "mirror", {6'd0, mirror_mode}, {6'd0, ext_mode ? mmir : {1'b0, mmir[0]}});
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      int idx;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a[15:13] == 3'b100 && !a[0]) msel = d;
      if (a[15:13] == 3'b100 && a[0]) begin
         idx = ext_mode ? int'(msel[3:0]) : int'(msel[2:0]);
         if (swap_67 && msel[6] && idx == 6) idx = 7;
         else if (swap_67 && msel[6] && idx == 7) idx = 6;
         if (idx < 12) m[idx] = d;
      end
      if (a[15:13] == 3'b101 && !a[0]) mmir = d[1:0];
   endtask

   task automatic set_mode(input logic e);
      @(negedge clk);
      ext_mode = e;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m[0] = 8'h00; m[1] = 8'h02; m[2] = 8'h04; m[3] = 8'h05;
      m[4] = 8'h06; m[5] = 8'h07; m[6] = 8'h00; m[7] = 8'h01;
      m[8] = 8'hFE; m[9] = 8'hFF; m[10] = 8'hFF; m[11] = 8'hFF;
      msel = 8'h00; mmir = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset contents in legacy and extended view; R11 level switch
      check_all("R1");
      set_mode(1'b1);
      check_all("R1/R11");
      set_mode(1'b0);

      // sweep every index under every inversion pair in both modes
      for (int md = 0; md < 2; md++) begin
         set_mode(md[0]);
         for (int ix = 0; ix < 16; ix++) begin
            for (int ib = 0; ib < 4; ib++) begin
               wr(16'h8000 | 16'(ix << 5), {ib[1:0], 2'b01, ix[3:0]});
               wr(16'h8001 | 16'(ib << 7), 8'(ix*29 + ib*71 + md*13 + 3));
               if (md == 0) check_all("R3/R5/R6/R8");
               else         check_all("R4/R5/R7/R8");
            end
         end
      end

      // R2: addresses outside the decoded windows, and a strobe-less pulse
      set_mode(1'b1);
      wr(16'h8000, 8'h82);
      wr(16'hA001, 8'hFF); check_all("R2");
      wr(16'hC000, 8'hFF); check_all("R2");
      wr(16'hC001, 8'hFF); check_all("R2");
      wr(16'hE000, 8'hFF); check_all("R2");
      wr(16'hE001, 8'hFF); check_all("R2");
      wr(16'h7FFF, 8'hFF); check_all("R2");
      wr(16'h6000, 8'hC3); check_all("R2");
      wr(16'h5001, 8'hFF); check_all("R2");
      @(negedge clk);
      wr_addr = 16'h8000; wr_data = 8'h4B;
      @(negedge clk);
      wr_addr = 16'h8001; wr_data = 8'h99;
      @(negedge clk);
      check_all("R2");
      wr(16'h9FFE, 8'h0B);
      wr(16'h9FFF, 8'h5D); check_all("R2");

      // R9: mirroring codes in both modes, at both ends of the window
      for (int md = 0; md < 2; md++) begin
         set_mode(md[0]);
         for (int v = 0; v < 4; v++) begin
            wr((v % 2) ? 16'hBFFE : 16'hA000, {6'h15, v[1:0]});
            check_all("R9");
         end
      end

      // R10: select-value exchange with the option on and off
      for (int md = 0; md < 2; md++) begin
         set_mode(md[0]);
         swap_67 = 1'b1;
         wr(16'h8000, 8'h46); wr(16'h8001, 8'h3C); check_all("R10");
         wr(16'h8000, 8'h47); wr(16'h8001, 8'h5A); check_all("R10");
         wr(16'h8000, 8'h06); wr(16'h8001, 8'h11); check_all("R10");
         wr(16'h8000, 8'h07); wr(16'h8001, 8'h22); check_all("R10");
         swap_67 = 1'b0;
         wr(16'h8000, 8'h46); wr(16'h8001, 8'h77); check_all("R10");
      end

      // R11: mode level flips with no write in between
      wr(16'h8000, 8'hC0);
      for (int t = 0; t < 4; t++) begin
         set_mode(t[0]);
         check_all("R11");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule